// File: doc/BRIEF.md
# Bunch-Crossing Tagged Hit Compaction Pipeline

This block sits between a bank of time-to-digital channels and an event buffer. On every bunch-crossing clock it takes one snapshot of all channels: a hit flag per channel and a short time code per channel. It turns that snapshot into one event record. Each record carries the value of a free-running crossing counter taken when the snapshot was sampled, a count of the channels that were hit, a format flag, and a list of channel entries.

In suppressed format, the entry list keeps only the channels that were hit. They are packed from slot 0 upward in ascending channel order. Each entry holds the channel index and the time code. In bypass format, every channel fills its own slot, hit or not. The format is chosen for each snapshot by a mode input. Compaction runs as a chain of one stage per channel. Each stage keeps a register of the hit flags still to be examined and a register of the data that goes with them. It moves at most one entry into the packed list. A record therefore leaves the chain a fixed number of clocks after it entered. One record enters and one record leaves on every clock.

Top module: `zs_compactor`

## Requirements
- R1: A snapshot sampled at a rising edge appears on the outputs right after the NCH-th rising edge, counting its sampling edge as the first. While reset is high, and until the first snapshot after reset reaches the end of the chain, out_valid is 0 and all record outputs are 0. From then on, out_valid is 1 on every clock.
- R2: The crossing counter is BXW bits wide, is cleared by the synchronous reset and increments on every clock. A record's out_bx equals the counter value at its sampling edge, so the first snapshot after reset is tagged 0 and the next snapshots are tagged 1, 2, and so on.
- R3: After 2^BXW-1 the crossing counter wraps to 0, and the tags follow it.
- R4: out_count equals the number of set bits of hit_vld at the sampling edge, in both formats.
- R5: In suppressed format (raw_mode=0 at sampling), slot k (out_entries[k*EW +: EW], with EW=CIW+TW) holds the k-th hit channel in ascending channel order. Each entry has the channel index in its upper CIW bits and that channel's time code in its lower TW bits.
- R6: In suppressed format, every slot from out_count upward is all zero.
- R7: A snapshot with no hits still yields a valid record, with out_count 0 and all slots zero.
- R8: In bypass format (raw_mode=1 at sampling), slot k holds {k, time code of channel k} for every channel, whether or not that channel was hit. out_suppressed is 0 for bypass records and 1 for suppressed records.
- R9: The format is taken per snapshot, so records of different formats on consecutive clocks each keep their own layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_mode | input | 1 | 1 selects bypass format for this snapshot |
| hit_vld | input | NCH | Hit flag per channel |
| hit_time | input | NCH*TW | Time code per channel, channel c at [c*TW +: TW] |
| out_valid | output | 1 | A record is present on the outputs |
| out_bx | output | BXW | Crossing tag of the record |
| out_suppressed | output | 1 | 1 for suppressed format, 0 for bypass |
| out_count | output | $clog2(NCH+1) | Number of hit channels |
| out_entries | output | NCH*(CIW+TW) | Entry slots, slot k at [k*EW +: EW] |

## Verification
Every result of a snapshot (tag, count, flag and entries) becomes visible after the sixteenth rising edge, counting from the one that samples it. So the bench drives a new snapshot at each falling edge and, at that same falling edge, checks the snapshot driven sixteen falling edges earlier. It does this against a record rebuilt from the stimulus function. Before the first record arrives, the bench checks that out_valid stays low. It runs more than 2^BXW snapshots so that the tag wrap is reached, and it checks the wrap at the exact snapshots where the counter rolls over.

// File: rtl/zs_pkg.sv
package zs_pkg;

   // Bits needed for a channel index, never less than one.
   function automatic int idx_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/zs_bx_counter.sv
module zs_bx_counter #(
   parameter int BXW = 12
) (
   input  logic           clk,
   input  logic           rst,
   output logic [BXW-1:0] bx_o
);

   localparam logic [BXW-1:0] BX_TOP = {BXW{1'b1}};

   always_ff @(posedge clk) begin
      if (rst) bx_o <= '0;
      else     bx_o <= bx_o + 1'b1;
   end

   // R3: the counter rolls from its top value back to zero
   a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
      (bx_o == BX_TOP) |=> (bx_o == '0));

endmodule

// File: rtl/zs_stage.sv
module zs_stage
   import zs_pkg::*;
#(
   parameter int NCH = 16,
   parameter int TW  = 4,
   parameter int BXW = 12,
   parameter int S   = 0
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 live_i,
   input  logic                                 raw_i,
   input  logic [BXW-1:0]                       bx_i,
   input  logic [NCH-1:0]                       vld_i,
   input  logic [NCH*TW-1:0]                    time_i,
   input  logic [$clog2(NCH+1)-1:0]             ptr_i,
   input  logic [$clog2(NCH+1)-1:0]             cnt_i,
   input  logic [NCH*(idx_bits(NCH)+TW)-1:0]    ent_i,
   output logic                                 live_o,
   output logic                                 raw_o,
   output logic [BXW-1:0]                       bx_o,
   output logic [NCH-1:0]                       vld_o,
   output logic [NCH*TW-1:0]                    time_o,
   output logic [$clog2(NCH+1)-1:0]             ptr_o,
   output logic [$clog2(NCH+1)-1:0]             cnt_o,
   output logic [NCH*(idx_bits(NCH)+TW)-1:0]    ent_o
);

   localparam int CIW = idx_bits(NCH);
   localparam int EW  = CIW + TW;
   localparam int CW  = $clog2(NCH + 1);
   localparam logic [CIW-1:0] IDX = CIW'(S);

   logic                take;
   logic [NCH-1:0]      vld_n;
   logic [NCH*TW-1:0]   time_n;
   logic [NCH*EW-1:0]   ent_n;
   logic [CW-1:0]       ptr_n;
   logic [CW-1:0]       cnt_n;

   // Examine channel S: move it into the packed list when selected,
   // then retire it from the still-to-check registers.
   always_comb begin
      take   = raw_i | vld_i[S];
      ent_n  = ent_i;
      for (int k = 0; k < NCH; k++) begin
         if (take && (ptr_i == CW'(k)))
            ent_n[k*EW +: EW] = {IDX, time_i[S*TW +: TW]};
      end
      vld_n            = vld_i;
      vld_n[S]         = 1'b0;
      time_n           = time_i;
      time_n[S*TW +: TW] = '0;
      ptr_n  = ptr_i + CW'(take);
      cnt_n  = cnt_i + CW'(vld_i[S]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         live_o <= 1'b0;
         raw_o  <= 1'b0;
         bx_o   <= '0;
         vld_o  <= '0;
         time_o <= '0;
         ptr_o  <= '0;
         cnt_o  <= '0;
         ent_o  <= '0;
      end else begin
         live_o <= live_i;
         raw_o  <= raw_i;
         bx_o   <= bx_i;
         vld_o  <= vld_n;
         time_o <= time_n;
         ptr_o  <= ptr_n;
         cnt_o  <= cnt_n;
         ent_o  <= ent_n;
      end
   end

   // R4: hits counted so far never exceed entries written so far
   a_r4_cnt_within_ptr: assert property (@(posedge clk) disable iff (rst)
      live_o |-> (cnt_o <= ptr_o));

   // R5: after stage S no more than S+1 entries can have been written
   a_r5_ptr_bound: assert property (@(posedge clk) disable iff (rst)
      live_o |-> (ptr_o <= CW'(S + 1)));

endmodule

// File: rtl/zs_compactor.sv
module zs_compactor
   import zs_pkg::*;
#(
   parameter int NCH = 16,
   parameter int TW  = 4,
   parameter int BXW = 12
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 raw_mode,
   input  logic [NCH-1:0]                       hit_vld,
   input  logic [NCH*TW-1:0]                    hit_time,
   output logic                                 out_valid,
   output logic [BXW-1:0]                       out_bx,
   output logic                                 out_suppressed,
   output logic [$clog2(NCH+1)-1:0]             out_count,
   output logic [NCH*(idx_bits(NCH)+TW)-1:0]    out_entries
);

   localparam int CIW = idx_bits(NCH);
   localparam int EW  = CIW + TW;
   localparam int CW  = $clog2(NCH + 1);

   generate
      if (NCH < 2) begin : g_bad_nch
         $error("zs_compactor: NCH must be at least 2");
      end
      if (TW < 1) begin : g_bad_tw
         $error("zs_compactor: TW must be at least 1");
      end
      if (BXW < 2) begin : g_bad_bxw
         $error("zs_compactor: BXW must be at least 2");
      end
   endgenerate

   logic [BXW-1:0] bx_now;

   zs_bx_counter #(.BXW(BXW)) u_bx (
      .clk  (clk),
      .rst  (rst),
      .bx_o (bx_now)
   );

   // Chain links: index 0 is the block input, index NCH the final record.
   logic                 c_live [NCH+1];
   logic                 c_raw  [NCH+1];
   logic [BXW-1:0]       c_bx   [NCH+1];
   logic [NCH-1:0]       c_vld  [NCH+1];
   logic [NCH*TW-1:0]    c_time [NCH+1];
   logic [CW-1:0]        c_ptr  [NCH+1];
   logic [CW-1:0]        c_cnt  [NCH+1];
   logic [NCH*EW-1:0]    c_ent  [NCH+1];

   assign c_live[0] = 1'b1;
   assign c_raw[0]  = raw_mode;
   assign c_bx[0]   = bx_now;
   assign c_vld[0]  = hit_vld;
   assign c_time[0] = hit_time;
   assign c_ptr[0]  = '0;
   assign c_cnt[0]  = '0;
   assign c_ent[0]  = '0;

   generate
      for (genvar s = 0; s < NCH; s++) begin : g_stage
         zs_stage #(.NCH(NCH), .TW(TW), .BXW(BXW), .S(s)) u_st (
            .clk    (clk),
            .rst    (rst),
            .live_i (c_live[s]),
            .raw_i  (c_raw[s]),
            .bx_i   (c_bx[s]),
            .vld_i  (c_vld[s]),
            .time_i (c_time[s]),
            .ptr_i  (c_ptr[s]),
            .cnt_i  (c_cnt[s]),
            .ent_i  (c_ent[s]),
            .live_o (c_live[s+1]),
            .raw_o  (c_raw[s+1]),
            .bx_o   (c_bx[s+1]),
            .vld_o  (c_vld[s+1]),
            .time_o (c_time[s+1]),
            .ptr_o  (c_ptr[s+1]),
            .cnt_o  (c_cnt[s+1]),
            .ent_o  (c_ent[s+1])
         );
      end
   endgenerate

   assign out_valid      = c_live[NCH];
   assign out_bx         = c_bx[NCH];
   assign out_suppressed = c_live[NCH] & ~c_raw[NCH];
   assign out_count      = c_cnt[NCH];
   assign out_entries    = c_ent[NCH];

   // R4: a record never reports more hits than there are channels
   a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_count <= CW'(NCH)));

   // R2: consecutive records carry consecutive crossing tags
   a_r2_bx_step: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(out_valid)) |-> (out_bx == $past(out_bx) + 1'b1));

   // R5: suppressed records hold exactly as many entries as hits
   a_r5_len_match: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_suppressed) |-> (c_ptr[NCH] == out_count));

   // R8: bypass records fill every slot
   a_r8_raw_full: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_suppressed) |-> (c_ptr[NCH] == CW'(NCH)));

   // R5: every channel has been examined by the end of the chain
   a_r5_all_checked: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ((c_vld[NCH] == '0) && (c_time[NCH] == '0)));

   // R5: packed entries appear in strictly ascending channel order
   always @(posedge clk) begin
      if (!rst && out_valid && out_suppressed) begin
         for (int k = 1; k < NCH; k++) begin
            if (CW'(k) < out_count) begin
               a_r5_ascending: assert (out_entries[k*EW+TW +: CIW] >
                                       out_entries[(k-1)*EW+TW +: CIW]);
            end
         end
      end
   end

endmodule

// File: tb/sim_zs_compactor.sv
module sim_zs_compactor;

   localparam int NCH = 16;
   localparam int TW  = 4;
   localparam int BXW = 12;
   localparam int CIW = 4;
   localparam int EW  = CIW + TW;
   localparam int CW  = 5;
   localparam int NEV = 4300;

   logic                 clk = 1'b0;
   logic                 rst;
   logic                 raw_mode;
   logic [NCH-1:0]       hit_vld;
   logic [NCH*TW-1:0]    hit_time;
   logic                 out_valid;
   logic [BXW-1:0]       out_bx;
   logic                 out_suppressed;
   logic [CW-1:0]        out_count;
   logic [NCH*EW-1:0]    out_entries;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   zs_compactor #(.NCH(NCH), .TW(TW), .BXW(BXW)) u0 (
      .clk(clk), .rst(rst), .raw_mode(raw_mode), .hit_vld(hit_vld),
      .hit_time(hit_time), .out_valid(out_valid), .out_bx(out_bx),
      .out_suppressed(out_suppressed), .out_count(out_count),
      .out_entries(out_entries)
   );

   task automatic check(input bit ok, input string req,
                        input logic [255:0] act, input logic [255:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Stimulus functions of the snapshot number.
   function automatic logic [31:0] mix(input int j);
      return (j * 32'h9E3779B1) + 32'h01234567;
   endfunction

   function automatic logic [NCH-1:0] pat_vld(input int j);
      logic [31:0] v = mix(j);
      if (j < NCH)       return NCH'(1) << j;
      if (j % 50 == 3)   return '0;
      if (j % 50 == 7)   return '1;
      case (j % 4)
         0: return v[31:16];
         1: return v[31:16] & v[15:0];
         2: return v[31:16] | v[15:0];
         default: return NCH'(1) << (j % NCH);
      endcase
   endfunction

   function automatic logic [NCH*TW-1:0] pat_time(input int j);
      logic [31:0] v = mix(j);
      return {v ^ 32'hA5A50F0F, v * 32'd7 + 32'(j)};
   endfunction

   function automatic logic pat_raw(input int j);
      return ((j / 37) % 3 == 1) || (j % 50 == 9);
   endfunction

   task automatic drive(input int j);
      raw_mode = (j < NEV) ? pat_raw(j) : 1'b0;
      hit_vld  = (j < NEV) ? pat_vld(j) : '0;
      hit_time = (j < NEV) ? pat_time(j) : '0;
   endtask

   task automatic check_event(input int j);
      logic [NCH-1:0]    v  = pat_vld(j);
      logic [NCH*TW-1:0] t  = pat_time(j);
      logic              rw = pat_raw(j);
      logic [NCH*EW-1:0] e  = '0;
      logic [NCH*EW-1:0] above = '0;
      int                n  = 0;
      int                p  = 0;
      string             tag;
      for (int c = 0; c < NCH; c++) begin
         if (v[c]) n++;
         if (rw || v[c]) begin
            e[p*EW +: EW] = {CIW'(c), t[c*TW +: TW]};
            p++;
         end
      end
      for (int k = 0; k < NCH; k++)
         if (k >= n) above[k*EW +: EW] = '1;
      check(out_valid == 1'b1, "R1 out_valid", 256'(out_valid), 256'(1));
      tag = (j >= 4095 && j <= 4097) ? "R3 bx wrap" : "R2 bx tag";
      check(out_bx == BXW'(j), tag, 256'(out_bx), 256'(BXW'(j)));
      check(out_count == CW'(n), "R4 count", 256'(out_count), 256'(n));
      check(out_suppressed == !rw, "R8 format flag",
            256'(out_suppressed), 256'(!rw));
      if (j > 0 && pat_raw(j - 1) != rw)      tag = "R9 mixed formats";
      else if (rw)                            tag = "R8 bypass slots";
      else if (n == 0)                        tag = "R7 empty record";
      else                                    tag = "R5 packed slots";
      check(out_entries == e, tag, 256'(out_entries), 256'(e));
      if (!rw)
         check((out_entries & above) == '0, "R6 unused slots zero",
               256'(out_entries & above), 256'(0));
   endtask

   initial begin
      rst = 1'b1;
      drive(NEV);
      repeat (4) @(negedge clk);
      check(out_valid == 1'b0, "R1 reset valid", 256'(out_valid), 256'(0));
      check(out_count == '0 && out_entries == '0 && out_bx == '0,
            "R1 reset record", 256'(out_entries), 256'(0));
      rst = 1'b0;
      for (int j = 0; j < NEV + NCH; j++) begin
         if (j >= NCH) check_event(j - NCH);
         else check(out_valid == 1'b0, "R1 fill latency",
                    256'(out_valid), 256'(0));
         drive(j);
         @(negedge clk);
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule